// File: doc/BRIEF.md
# Time-of-day alarm comparator with wildcard fields

This block decides, once per second, whether the time of day has reached a programmed alarm. On each update-ended strobe from the timekeeping logic it compares the just-incremented seconds, minutes and hours against three alarm bytes. It then reports a match to the interrupt flag logic. Any alarm byte can be turned into a wildcard. That makes alarms that repeat every second, every minute or every hour possible with no further settings.

Both the time bytes and the alarm bytes are decoded under the same encoding (packed BCD or plain binary) and the same hour convention (12-hour with a PM bit, or 24-hour). Hours are folded to a 0..23 value before comparison. A sticky alarm flag records the match until the flag-clear strobe. A one-cycle interrupt request is issued only when the alarm interrupt is enabled and the flag was not already set.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After synchronous reset, `alarm_match`, `alarm_flag` and `irq_pulse` are all 0.
- R2: When `upd_pulse` is high in cycle N, the dividers are running and every field matches, `alarm_match` is 1 in cycle N+1 only.
- R3: A mismatch in any one of seconds, minutes or hours gives no `alarm_match` for that update.
- R4: An alarm byte whose bits 7:6 are both 1 matches any current value of its field. With all three alarm bytes in that form, every update produces a match.
- R5: With `bin_mode`=1 the fields are read as plain binary. With `bin_mode`=0 they are read as packed BCD (tens in bits 6:4, units in bits 3:0).
- R6: With `hr24`=0, hour bit 7 is the PM bit, the low bits hold 1..12, and 12 AM equals hour 0. Alarm and time hours are compared after folding to 0..23. With `hr24`=1, bit 7 is not treated as PM.
- R7: While `div_hold` is 1, no update produces a match, a flag or an interrupt.
- R8: A match sets `alarm_flag`. The flag stays set until `flag_clr`, and a match in the same cycle as `flag_clr` leaves it set.
- R9: `irq_pulse` is 1 for one cycle with `alarm_match` only if `alarm_en` was 1 and `alarm_flag` was 0 in the update cycle.
- R10: Without `upd_pulse`, matching time and alarm values give no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_pulse | input | 1 | One-cycle strobe after the time registers advance |
| div_hold | input | 1 | Dividers held in reset; suppresses matching |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| alarm_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clears the sticky alarm flag |
| t_sec | input | 8 | Current seconds |
| t_min | input | 8 | Current minutes |
| t_hour | input | 8 | Current hours |
| al_sec | input | 8 | Alarm seconds (wildcard when bits 7:6 = 11) |
| al_min | input | 8 | Alarm minutes (wildcard when bits 7:6 = 11) |
| al_hour | input | 8 | Alarm hours (wildcard when bits 7:6 = 11) |
| alarm_match | output | 1 | One-cycle match pulse |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench targets the hour folding in 12-hour mode, which is easy to get wrong:
- 12 PM against 12 AM must differ, while 12 AM and a zero hour must agree. A design comparing raw bytes would miss the second case.
- A design that forgot to fold the hour would get both wrong.
- In 24-hour mode, bit 7 must not act as PM.

Wildcard detection is also probed. A PM hour has bits 7:6 = 10, so a one-bit wildcard test would treat PM alarms as don't-care.

Further tests:
- A set-and-clear collision on the flag, where a design that lets the clear win would lose an alarm.
- A repeated match with the flag still set, where a design would re-raise the interrupt.
- An update strobe with the dividers held, which must fire nothing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FW = 8;           // width of one time/alarm byte
  localparam int VW = FW - 1;      // width of a decoded value
  localparam int NF = 3;           // number of compared fields
  localparam int HOUR_IDX = 2;     // field index of hours
  localparam int HALF_DAY = 12;

  // packed BCD (tens in [6:4], units in [3:0]) or binary to binary
  function automatic logic [VW-1:0] to_bin(input logic [VW-1:0] v, input logic bin);
    logic [VW-1:0] tens;
    logic [VW-1:0] units;
    tens  = VW'(v[VW-1:4]);
    units = VW'(v[3:0]);
    return bin ? v : VW'(tens * VW'(10) + units);
  endfunction
endpackage

// File: rtl/rtc_field_decode.sv
module rtc_field_decode
  import rtc_alarm_pkg::*;
#(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [FW-1:0] raw,
  input  logic          bin_mode,
  input  logic          hr24,
  output logic [VW-1:0] val,
  output logic          wild
);
  logic [VW-1:0] plain;

  assign plain = to_bin(raw[VW-1:0], bin_mode);
  assign wild  = (raw[FW-1:FW-2] == 2'b11);

  generate
    if (IS_HOUR) begin : g_hour
      logic [VW-1:0] folded;
      // 12 AM folds to 0, PM adds half a day
      assign folded = VW'(plain % VW'(HALF_DAY));
      assign val = hr24 ? plain : (raw[FW-1] ? VW'(folded + VW'(HALF_DAY)) : folded);
    end else begin : g_plain
      assign val = plain;
    end
  endgenerate
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NF-1:0][FW-1:0] time_raw,
  input  logic [NF-1:0][FW-1:0] alarm_raw,
  input  logic                  bin_mode,
  input  logic                  hr24,
  output logic                  hit
);
  logic [NF-1:0] field_hit;

  generate
    for (genvar g = 0; g < NF; g++) begin : g_field
      logic [VW-1:0] tv;
      logic [VW-1:0] av;
      logic          t_wild_unused;
      logic          a_wild;

      rtc_field_decode #(.IS_HOUR(g == HOUR_IDX)) u_tdec (
        .raw(time_raw[g]), .bin_mode(bin_mode), .hr24(hr24),
        .val(tv), .wild(t_wild_unused)
      );
      rtc_field_decode #(.IS_HOUR(g == HOUR_IDX)) u_adec (
        .raw(alarm_raw[g]), .bin_mode(bin_mode), .hr24(hr24),
        .val(av), .wild(a_wild)
      );

      assign field_hit[g] = a_wild | (tv == av);
    end
  endgenerate

  assign hit = &field_hit;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_pulse,
  input  logic          div_hold,
  input  logic          bin_mode,
  input  logic          hr24,
  input  logic          alarm_en,
  input  logic          flag_clr,
  input  logic [FW-1:0] t_sec,
  input  logic [FW-1:0] t_min,
  input  logic [FW-1:0] t_hour,
  input  logic [FW-1:0] al_sec,
  input  logic [FW-1:0] al_min,
  input  logic [FW-1:0] al_hour,
  output logic          alarm_match,
  output logic          alarm_flag,
  output logic          irq_pulse
);
  logic [NF-1:0][FW-1:0] time_raw;
  logic [NF-1:0][FW-1:0] alarm_raw;
  logic                  hit;
  logic                  fire;

  assign time_raw  = {t_hour, t_min, t_sec};
  assign alarm_raw = {al_hour, al_min, al_sec};

  rtc_alarm_match u_match (
    .time_raw(time_raw), .alarm_raw(alarm_raw),
    .bin_mode(bin_mode), .hr24(hr24), .hit(hit)
  );

  assign fire = upd_pulse & ~div_hold & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_match <= 1'b0;
      alarm_flag  <= 1'b0;
      irq_pulse   <= 1'b0;
    end else begin
      alarm_match <= fire;
      irq_pulse   <= fire & alarm_en & ~alarm_flag;
      alarm_flag  <= fire | (alarm_flag & ~flag_clr);
    end
  end

  a_r2_match_needs_update: assert property (@(posedge clk) disable iff (rst)
    alarm_match |-> $past(upd_pulse));
  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(div_hold) |-> !alarm_match);
  a_r4_all_wild_fires: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse && !div_hold && al_sec[FW-1:FW-2] == 2'b11 &&
     al_min[FW-1:FW-2] == 2'b11 && al_hour[FW-1:FW-2] == 2'b11) |=> alarm_match);
  a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
    alarm_match |-> alarm_flag);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(alarm_flag) && !$past(flag_clr)) |-> alarm_flag);
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (alarm_match && $past(alarm_en) && !$past(alarm_flag)));
endmodule

// File: tb/tb_rtc_alarm_cmp.sv
module tb_rtc_alarm_cmp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_pulse = 0, div_hold = 0, bin_mode = 0, hr24 = 1, alarm_en = 0, flag_clr = 0;
  logic [7:0] t_sec = 0, t_min = 0, t_hour = 0, al_sec = 0, al_min = 0, al_hour = 0;
  logic alarm_match, alarm_flag, irq_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_alarm_cmp dut (
    .clk(clk), .rst(rst), .upd_pulse(upd_pulse), .div_hold(div_hold),
    .bin_mode(bin_mode), .hr24(hr24), .alarm_en(alarm_en), .flag_clr(flag_clr),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
    .alarm_match(alarm_match), .alarm_flag(alarm_flag), .irq_pulse(irq_pulse)
  );

  // {exp, bin, hr24, ts, tm, th, as, am, ah}
  localparam int NV = 15;
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 8'h30, 8'h15, 8'h09, 8'h30, 8'h15, 8'h09},  // R2 exact BCD
    {1'b0, 1'b0, 1'b1, 8'h31, 8'h15, 8'h09, 8'h30, 8'h15, 8'h09},  // R3 sec
    {1'b0, 1'b0, 1'b1, 8'h30, 8'h16, 8'h09, 8'h30, 8'h15, 8'h09},  // R3 min
    {1'b0, 1'b0, 1'b1, 8'h30, 8'h15, 8'h10, 8'h30, 8'h15, 8'h09},  // R3 hour
    {1'b1, 1'b0, 1'b1, 8'h42, 8'h07, 8'h23, 8'hC0, 8'hFF, 8'hC5},  // R4 all wild
    {1'b1, 1'b0, 1'b1, 8'h59, 8'h07, 8'h23, 8'hFF, 8'h07, 8'h23},  // R4 sec wild
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h33, 8'h05, 8'h00, 8'hC0, 8'h05},  // R4 min wild
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h33, 8'h05, 8'hC0, 8'hC0, 8'h06},  // R4 hour not wild
    {1'b1, 1'b1, 1'b1, 8'h3B, 8'h0A, 8'h17, 8'h3B, 8'h0A, 8'h17},  // R5 binary
    {1'b0, 1'b1, 1'b1, 8'h3B, 8'h0A, 8'h17, 8'h3A, 8'h0A, 8'h17},  // R5 binary miss
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h92},  // R6 12 PM
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12},  // R6 12 AM vs PM
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h13, 8'h00, 8'h00, 8'h81},  // R6 no PM in 24h
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h8C},  // R6 binary 12 PM
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00}   // R6 12 AM folds to 0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_fields(input logic [7:0] ts, tm, th, as_, am, ah);
    t_sec = ts; t_min = tm; t_hour = th; al_sec = as_; al_min = am; al_hour = ah;
  endtask

  // drive one update strobe; returns at the negedge after the capturing edge
  task automatic do_update();
    @(negedge clk) upd_pulse = 1'b1;
    @(negedge clk) upd_pulse = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 match", alarm_match, 1'b0);
    chk("R1 flag", alarm_flag, 1'b0);
    chk("R1 irq", irq_pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bin_mode = VEC[i][49];
      hr24     = VEC[i][48];
      set_fields(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24],
                 VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      do_update();
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d match", i), alarm_match, VEC[i][50]);
      chk($sformatf("R8 vector %0d flag", i), alarm_flag, VEC[i][50]);
      clear_flag();
    end

    // R2: pulse lasts one cycle
    bin_mode = 0; hr24 = 1;
    set_fields(8'h10, 8'h20, 8'h08, 8'h10, 8'h20, 8'h08);
    do_update();
    chk("R2 pulse", alarm_match, 1'b1);
    @(negedge clk);
    chk("R2 single cycle", alarm_match, 1'b0);
    clear_flag();

    // R10: matching values without strobe
    repeat (5) @(negedge clk);
    chk("R10 no strobe match", alarm_match, 1'b0);
    chk("R10 no strobe flag", alarm_flag, 1'b0);

    // R7: dividers held, all wildcards
    div_hold = 1'b1;
    set_fields(8'h01, 8'h02, 8'h03, 8'hC0, 8'hC0, 8'hC0);
    do_update();
    chk("R7 hold match", alarm_match, 1'b0);
    chk("R7 hold flag", alarm_flag, 1'b0);
    @(negedge clk) div_hold = 1'b0;

    // R9: irq only when enabled and flag clear
    alarm_en = 1'b0;
    do_update();
    chk("R9 disabled irq", irq_pulse, 1'b0);
    chk("R9 disabled match", alarm_match, 1'b1);
    clear_flag();
    alarm_en = 1'b1;
    do_update();
    chk("R9 enabled irq", irq_pulse, 1'b1);
    @(negedge clk);
    chk("R9 irq single cycle", irq_pulse, 1'b0);
    do_update();
    chk("R9 flag already set match", alarm_match, 1'b1);
    chk("R9 flag already set irq", irq_pulse, 1'b0);

    // R8: clear and match in the same cycle, set wins
    @(negedge clk) begin flag_clr = 1'b1; upd_pulse = 1'b1; end
    @(negedge clk) begin flag_clr = 1'b0; upd_pulse = 1'b0; end
    chk("R8 set beats clear", alarm_flag, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", alarm_flag, 1'b1);
    clear_flag();
    chk("R8 flag cleared", alarm_flag, 1'b0);

    // R1: reset mid-run
    do_update();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 reset flag", alarm_flag, 1'b0);
    chk("R1 reset irq", irq_pulse, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule